// File: doc/BRIEF.md
# ADC Conversion Sequencer

This block is the digital control around a multi-channel successive-approximation converter. It decides which analog channel is converted next, issues a one-cycle start strobe with a channel number to the converter, and waits for the converter's done strobe and 12-bit result. The result goes either to a per-channel result register or to a small first-in first-out buffer, depending on the mode.

Four modes are available. Single mode converts one selected channel once. Burst mode converts one selected channel over and over, queueing each sample. Single-pass scan walks every enabled channel once, from the lowest index upward. Looping scan repeats that pass until software stops it. A sequence can be started by a software bit, by an edge on an external pin, by a timer overflow pulse, or by a PWM trigger. Each source has its own enable.

Every per-channel result register carries a valid flag and an overrun flag. Software reads a result by selecting a channel and strobing a read, which clears both flags.

Top module: `adc_seq_top`

## Requirements
- R1: After reset `busy`, `conv_start`, `fifo_full` and `fifo_ovr` are 0, `fifo_empty` is 1, and every channel reads back with valid and overrun clear.
- R2: With `cfg_mode` = 0 (single), a trigger runs exactly one conversion on `cfg_chan`. Its result is stored in that channel's register with valid set, and `busy` returns to 0 by itself once the result is taken.
- R3: With `cfg_mode` = 2 (single-pass scan), a trigger converts each channel i whose bit i of `cfg_ch_en` is 1 exactly once, in ascending index order. Each result goes to that channel's register, and `busy` then clears by itself. With `cfg_ch_en` all zero, a trigger starts nothing.
- R4: With `cfg_mode` = 3 (looping scan), ascending passes over the enabled channels repeat without end. After `sw_stop`, the conversion already in flight completes and no further conversion starts.
- R5: With `cfg_mode` = 1 (burst), `cfg_chan` is converted repeatedly and every result is queued. `fifo_data` shows the oldest entry and `fifo_pop` removes it. Channel registers are not written in this mode.
- R6: The queue holds 8 entries. A result arriving while it is full is dropped and sets `fifo_ovr`, and the first 8 entries are kept. A pop of a non-empty queue clears `fifo_ovr`.
- R7: A sequence starts on `sw_go`, on an `ext_pin` edge while `ext_en` is 1 (`ext_fall` = 0 selects a rising edge, 1 a falling edge), on `tmr_ovf[k]` while `tmr_en[k]` is 1, or on `pwm_trig` while `pwm_en` is 1. Disabled sources, the opposite pin edge, and any trigger while `busy` is 1 start nothing. While `busy` is 0 `conv_start` stays low.
- R8: A result written to a channel whose valid flag is still set sets that channel's overrun flag.
- R9: A read (`rd_en` with `rd_chan`) returns that channel's data, valid and overrun in the same cycle and clears valid and overrun from the next cycle.
- R10: When a read and a new result hit the same channel in the same cycle, the read returns the old data. Afterwards the channel holds the new data with valid set and overrun clear.
- R11: `conv_start` is a single-cycle pulse, and `conv_chan` holds its value from that pulse until `conv_done`. Only one conversion is outstanding at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_mode | input | 2 | 0 single, 1 burst, 2 single-pass scan, 3 looping scan |
| cfg_chan | input | 5 | Channel for single and burst modes |
| cfg_ch_en | input | 17 | Scan enable, bit i for channel i |
| sw_go | input | 1 | Software start pulse |
| sw_stop | input | 1 | Software stop pulse, wins over a start in the same cycle |
| ext_pin | input | 1 | External trigger pin, already synchronous |
| ext_en | input | 1 | Enables the pin trigger |
| ext_fall | input | 1 | Pin edge select: 0 rising, 1 falling |
| tmr_ovf | input | 4 | Timer overflow pulses |
| tmr_en | input | 4 | Per-timer trigger enable |
| pwm_trig | input | 1 | PWM trigger pulse |
| pwm_en | input | 1 | Enables the PWM trigger |
| busy | output | 1 | Sequence active |
| conv_start | output | 1 | Start strobe to the converter |
| conv_chan | output | 5 | Channel to convert |
| conv_done | input | 1 | Converter finished, `conv_data` valid |
| conv_data | input | 12 | Conversion result |
| rd_en | input | 1 | Read strobe, clears the flags of `rd_chan` |
| rd_chan | input | 5 | Channel to read |
| rd_data | output | 12 | Stored result of `rd_chan` |
| rd_valid | output | 1 | Valid flag of `rd_chan` |
| rd_ovr | output | 1 | Overrun flag of `rd_chan` |
| fifo_pop | input | 1 | Remove the oldest queued sample |
| fifo_data | output | 12 | Oldest queued sample |
| fifo_empty | output | 1 | Queue empty |
| fifo_full | output | 1 | Queue full |
| fifo_ovr | output | 1 | A sample was dropped |

## Verification
Two functions can fall in the same cycle: the result write that follows `conv_done` and a software read of the same channel register. The bench provokes this by having its converter model drive `rd_en` for that channel at the very edge where it raises `conv_done`. It then judges the outcome three ways: the data sampled in that cycle must be the previous result, a later read must return the new result with valid set, and overrun must be clear.

// File: rtl/adc_seq_pkg.sv
// Package: shared types for the conversion sequencer.
package adc_seq_pkg;
    // Operating mode, encoded as on the cfg_mode port
    typedef enum logic [1:0] {
        MODE_SINGLE    = 2'd0,
        MODE_BURST     = 2'd1,
        MODE_SCAN_ONCE = 2'd2,
        MODE_SCAN_LOOP = 2'd3
    } seq_mode_e;

    // Handshake state toward the converter
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } seq_state_e;
endpackage

// File: rtl/adc_seq_trig.sv
// Trigger combiner: merges software, pin-edge, timer and PWM start sources
// into one start request.
// Assumes ext_pin is already synchronous to clk and is low during reset.
module adc_seq_trig #(
    parameter int NUM_TMR = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sw_go,
    input  logic               ext_pin,
    input  logic               ext_en,
    input  logic               ext_fall,
    input  logic [NUM_TMR-1:0] tmr_ovf,
    input  logic [NUM_TMR-1:0] tmr_en,
    input  logic               pwm_trig,
    input  logic               pwm_en,
    output logic               trig
);
    logic pin_q;
    logic pin_edge;

    // Remember the pin level of the previous cycle
    always_ff @(posedge clk) begin
        if (!rst_n) pin_q <= 1'b0;
        else        pin_q <= ext_pin;
    end

    // Edge detect with selectable polarity
    always_comb begin
        if (ext_fall) pin_edge = pin_q & ~ext_pin;
        else          pin_edge = ~pin_q & ext_pin;
    end

    // Any enabled source requests a start
    assign trig = sw_go | (ext_en & pin_edge) | (|(tmr_ovf & tmr_en)) | (pwm_en & pwm_trig);
endmodule

// File: rtl/adc_seq_pick.sv
// Scan channel picker: finds the lowest enabled channel, and the lowest
// enabled channel above the one in flight.
// Assumes the enable mask is held stable while a scan runs.
module adc_seq_pick #(
    parameter int NUM_CH = 17,
    localparam int CH_W  = $clog2(NUM_CH)
) (
    input  logic [NUM_CH-1:0] ch_en,
    input  logic [CH_W-1:0]   cur_ch,
    output logic [CH_W-1:0]   first_ch,
    output logic [CH_W-1:0]   nxt_ch,
    output logic              any_en,
    output logic              nxt_found
);
    // Priority search from the top so the lowest index wins
    always_comb begin
        first_ch  = '0;
        nxt_ch    = '0;
        nxt_found = 1'b0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (ch_en[i]) begin
                first_ch = CH_W'(i);
                if (i > int'(cur_ch)) begin
                    nxt_ch    = CH_W'(i);
                    nxt_found = 1'b1;
                end
            end
        end
    end

    assign any_en = |ch_en;
endmodule

// File: rtl/adc_seq_bank.sv
// Result bank: one data word per channel with valid and overrun flags.
// Assumes at most one write and one read per cycle. A read returns the
// stored word combinationally; on a same-channel write the old word is read.
module adc_seq_bank #(
    parameter int NUM_CH = 17,
    parameter int RES_W  = 12,
    localparam int CH_W  = $clog2(NUM_CH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CH_W-1:0]  wr_ch,
    input  logic [RES_W-1:0] wr_data,
    input  logic             rd_en,
    input  logic [CH_W-1:0]  rd_ch,
    output logic [RES_W-1:0] rd_data,
    output logic             rd_valid,
    output logic             rd_ovr
);
    logic [RES_W-1:0]  data_q [NUM_CH];
    logic [NUM_CH-1:0] vld_q;
    logic [NUM_CH-1:0] ovr_q;
    logic [NUM_CH-1:0] wr_sel;
    logic [NUM_CH-1:0] rd_sel;
    logic              rd_hit;

    // Decode write and read targets
    always_comb begin
        for (int i = 0; i < NUM_CH; i++) begin
            wr_sel[i] = wr_en && (int'(wr_ch) == i);
            rd_sel[i] = rd_en && (int'(rd_ch) == i);
        end
    end

    // Update data and flags; a read in the write cycle consumes the old word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
            ovr_q <= '0;
            for (int i = 0; i < NUM_CH; i++) data_q[i] <= '0;
        end else begin
            for (int i = 0; i < NUM_CH; i++) begin
                if (wr_sel[i]) begin
                    data_q[i] <= wr_data;
                    vld_q[i]  <= 1'b1;
                    ovr_q[i]  <= (vld_q[i] | ovr_q[i]) & ~rd_sel[i];
                end else if (rd_sel[i]) begin
                    vld_q[i]  <= 1'b0;
                    ovr_q[i]  <= 1'b0;
                end
            end
        end
    end

    // Read mux with out-of-range guard
    assign rd_hit   = int'(rd_ch) < NUM_CH;
    assign rd_data  = rd_hit ? data_q[rd_ch] : '0;
    assign rd_valid = rd_hit & vld_q[rd_ch];
    assign rd_ovr   = rd_hit & ovr_q[rd_ch];
endmodule

// File: rtl/adc_seq_fifo.sv
// Burst queue: first-in first-out store with a sticky drop flag.
// Assumes DEPTH is a power of two of at least 2. A push while full is
// accepted only if a pop happens in the same cycle.
module adc_seq_fifo #(
    parameter int DEPTH = 8,
    parameter int WIDTH = 12,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic             empty,
    output logic             full,
    output logic             ovr
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wp, rp;
    logic [AW:0]      cnt;
    logic             do_push, do_pop;

    assign empty   = (cnt == '0);
    assign full    = (cnt == (AW+1)'(DEPTH));
    assign do_pop  = pop && !empty;
    assign do_push = push && (!full || do_pop);
    assign dout    = mem[rp];

    // Pointers, storage, fill count and drop flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
            ovr <= 1'b0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else begin
            if (do_push) begin
                mem[wp] <= din;
                wp      <= wp + 1'b1;
            end
            if (do_pop) rp <= rp + 1'b1;
            cnt <= cnt + {{AW{1'b0}}, do_push} - {{AW{1'b0}}, do_pop};
            if (push && !do_push) ovr <= 1'b1;
            else if (do_pop)      ovr <= 1'b0;
        end
    end
endmodule

// File: rtl/adc_seq_top.sv
// Conversion sequencer top: runs single, burst and scan sequences, drives
// the converter handshake and routes results to the bank or the queue.
// Assumes cfg_mode, cfg_chan and cfg_ch_en are stable while busy, and that
// the converter answers each start with exactly one conv_done.
module adc_seq_top
    import adc_seq_pkg::*;
#(
    parameter int NUM_CH     = 17,
    parameter int RES_W      = 12,
    parameter int FIFO_DEPTH = 8,
    parameter int NUM_TMR    = 4,
    localparam int CH_W      = $clog2(NUM_CH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         cfg_mode,
    input  logic [CH_W-1:0]    cfg_chan,
    input  logic [NUM_CH-1:0]  cfg_ch_en,
    input  logic               sw_go,
    input  logic               sw_stop,
    input  logic               ext_pin,
    input  logic               ext_en,
    input  logic               ext_fall,
    input  logic [NUM_TMR-1:0] tmr_ovf,
    input  logic [NUM_TMR-1:0] tmr_en,
    input  logic               pwm_trig,
    input  logic               pwm_en,
    output logic               busy,
    output logic               conv_start,
    output logic [CH_W-1:0]    conv_chan,
    input  logic               conv_done,
    input  logic [RES_W-1:0]   conv_data,
    input  logic               rd_en,
    input  logic [CH_W-1:0]    rd_chan,
    output logic [RES_W-1:0]   rd_data,
    output logic               rd_valid,
    output logic               rd_ovr,
    input  logic               fifo_pop,
    output logic [RES_W-1:0]   fifo_data,
    output logic               fifo_empty,
    output logic               fifo_full,
    output logic               fifo_ovr
);
    seq_mode_e  mode;
    seq_state_e state;
    logic            active;
    logic [CH_W-1:0] cur_ch, scan_ptr, pick_ch, first_ch, nxt_ch;
    logic            any_en, nxt_found, trig;
    logic            is_scan, start_ok, done_ev, pass_end;

    assign mode     = seq_mode_e'(cfg_mode);
    assign is_scan  = (mode == MODE_SCAN_ONCE) || (mode == MODE_SCAN_LOOP);
    assign pick_ch  = is_scan ? scan_ptr : cfg_chan;
    assign done_ev  = (state == ST_WAIT) && conv_done;
    assign start_ok = trig && !active && (state == ST_IDLE) && !sw_stop && (any_en || !is_scan);
    assign pass_end = (mode == MODE_SINGLE) || ((mode == MODE_SCAN_ONCE) && !nxt_found);

    adc_seq_trig #(.NUM_TMR(NUM_TMR)) u_trig (
        .clk      (clk),
        .rst_n    (rst_n),
        .sw_go    (sw_go),
        .ext_pin  (ext_pin),
        .ext_en   (ext_en),
        .ext_fall (ext_fall),
        .tmr_ovf  (tmr_ovf),
        .tmr_en   (tmr_en),
        .pwm_trig (pwm_trig),
        .pwm_en   (pwm_en),
        .trig     (trig)
    );

    adc_seq_pick #(.NUM_CH(NUM_CH)) u_pick (
        .ch_en     (cfg_ch_en),
        .cur_ch    (cur_ch),
        .first_ch  (first_ch),
        .nxt_ch    (nxt_ch),
        .any_en    (any_en),
        .nxt_found (nxt_found)
    );

    // Converter handshake: issue a start, then wait for done
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            cur_ch <= '0;
        end else begin
            case (state)
                ST_IDLE: if (active) begin
                    state  <= ST_WAIT;
                    cur_ch <= pick_ch;
                end
                ST_WAIT: if (conv_done) state <= ST_IDLE;
            endcase
        end
    end

    // Run flag: set by a trigger, cleared by stop or at the end of a pass
    always_ff @(posedge clk) begin
        if (!rst_n)                 active <= 1'b0;
        else if (sw_stop)           active <= 1'b0;
        else if (start_ok)          active <= 1'b1;
        else if (done_ev && pass_end) active <= 1'b0;
    end

    // Scan pointer: first enabled on start, then ascending with wrap
    always_ff @(posedge clk) begin
        if (!rst_n)                 scan_ptr <= '0;
        else if (start_ok)          scan_ptr <= first_ch;
        else if (done_ev && is_scan) scan_ptr <= nxt_found ? nxt_ch : first_ch;
    end

    adc_seq_bank #(.NUM_CH(NUM_CH), .RES_W(RES_W)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (done_ev && (mode != MODE_BURST)),
        .wr_ch    (cur_ch),
        .wr_data  (conv_data),
        .rd_en    (rd_en),
        .rd_ch    (rd_chan),
        .rd_data  (rd_data),
        .rd_valid (rd_valid),
        .rd_ovr   (rd_ovr)
    );

    adc_seq_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(RES_W)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (done_ev && (mode == MODE_BURST)),
        .din   (conv_data),
        .pop   (fifo_pop),
        .dout  (fifo_data),
        .empty (fifo_empty),
        .full  (fifo_full),
        .ovr   (fifo_ovr)
    );

    assign busy       = active;
    assign conv_start = (state == ST_IDLE) && active;
    assign conv_chan  = (state == ST_IDLE) ? pick_ch : cur_ch;
endmodule

// File: rtl/adc_seq_chk.sv
// Checker: temporal properties of the sequencer, attached by bind.
// Assumes it observes only top-level ports.
module adc_seq_chk #(
    parameter int NUM_CH = 17,
    localparam int CH_W  = $clog2(NUM_CH)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            conv_start,
    input logic [CH_W-1:0] conv_chan,
    input logic            busy,
    input logic            fifo_empty,
    input logic            fifo_full,
    input logic            fifo_ovr,
    input logic            fifo_pop
);
    // R11
    start_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);

    // R11
    chan_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> $stable(conv_chan));

    // R7
    idle_no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !conv_start);

    // R6
    drop_needs_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fifo_ovr) |-> $past(fifo_full));

    // R6
    pop_clears_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_pop && !fifo_empty) |=> !fifo_ovr);

    // R6
    full_empty_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fifo_full, fifo_empty}));
endmodule

bind adc_seq_top adc_seq_chk #(.NUM_CH(NUM_CH)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .conv_start (conv_start),
    .conv_chan  (conv_chan),
    .busy       (busy),
    .fifo_empty (fifo_empty),
    .fifo_full  (fifo_full),
    .fifo_ovr   (fifo_ovr),
    .fifo_pop   (fifo_pop)
);

// File: tb/test_adc_seq_top.sv
// Bench: random and directed sequences against a behavioural converter.
module test_adc_seq_top;
    localparam int CLK_PERIOD = 10;
    localparam int NUM_CH     = 17;
    localparam int CH_W       = 5;

    logic clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic              rst_n;
    logic [1:0]        cfg_mode;
    logic [CH_W-1:0]   cfg_chan;
    logic [NUM_CH-1:0] cfg_ch_en;
    logic sw_go, sw_stop, ext_pin, ext_en, ext_fall, pwm_trig, pwm_en;
    logic [3:0]        tmr_ovf, tmr_en;
    logic              busy, conv_start, conv_done;
    logic [CH_W-1:0]   conv_chan, rd_chan;
    logic [11:0]       conv_data, rd_data, fifo_data;
    logic              rd_en, rd_valid, rd_ovr, fifo_pop, fifo_empty, fifo_full, fifo_ovr;

    adc_seq_top i_adc_seq_top (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_chan(cfg_chan),
        .cfg_ch_en(cfg_ch_en), .sw_go(sw_go), .sw_stop(sw_stop), .ext_pin(ext_pin),
        .ext_en(ext_en), .ext_fall(ext_fall), .tmr_ovf(tmr_ovf), .tmr_en(tmr_en),
        .pwm_trig(pwm_trig), .pwm_en(pwm_en), .busy(busy), .conv_start(conv_start),
        .conv_chan(conv_chan), .conv_done(conv_done), .conv_data(conv_data),
        .rd_en(rd_en), .rd_chan(rd_chan), .rd_data(rd_data), .rd_valid(rd_valid),
        .rd_ovr(rd_ovr), .fifo_pop(fifo_pop), .fifo_data(fifo_data),
        .fifo_empty(fifo_empty), .fifo_full(fifo_full), .fifo_ovr(fifo_ovr)
    );

    int checks = 0;
    int errs   = 0;
    int log_n  = 0;
    int log_ch [1024];
    logic [11:0] log_d [1024];
    int   lat_fix  = 0;
    bit   inflight = 0;
    bit   coll_arm = 0;
    bit   coll_pend = 0;
    logic [11:0] coll_old;

    function automatic logic [11:0] conv_val(int ch, int n);
        return 12'((ch * 97 + n * 13 + 5) & 4095);
    endfunction

    function automatic int popc(logic [NUM_CH-1:0] m);
        int c = 0;
        for (int i = 0; i < NUM_CH; i++) c += int'(m[i]);
        return c;
    endfunction

    function automatic int nth_en(logic [NUM_CH-1:0] m, int k);
        int c = 0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (m[i]) begin
                if (c == k) return i;
                c++;
            end
        end
        return -1;
    endfunction

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Converter model: answers each start after a latency, can arm a colliding read
    initial begin
        conv_done = 1'b0;
        conv_data = '0;
        forever begin
            @(negedge clk);
            if (conv_done) inflight = 0;
            conv_done = 1'b0;
            if (coll_pend) begin rd_en = 1'b0; coll_pend = 0; end
            if (conv_start) begin
                int ch;
                int lat;
                logic [11:0] d;
                ch  = int'(conv_chan);
                d   = conv_val(ch, log_n);
                if (log_n < 1024) begin log_ch[log_n] = ch; log_d[log_n] = d; end
                log_n++;
                inflight = 1;
                lat = (lat_fix != 0) ? lat_fix : 1 + int'($urandom % 4);
                repeat (lat) @(negedge clk);
                conv_done = 1'b1;
                conv_data = d;
                if (coll_arm) begin
                    rd_chan  = CH_W'(ch);
                    rd_en    = 1'b1;
                    coll_arm = 0;
                    coll_pend = 1;
                    #1 coll_old = rd_data;
                end
            end
        end
    end

    task automatic pulse_go;
        @(negedge clk); sw_go = 1'b1;
        @(negedge clk); sw_go = 1'b0;
    endtask

    task automatic pulse_stop;
        @(negedge clk); sw_stop = 1'b1;
        @(negedge clk); sw_stop = 1'b0;
    endtask

    task automatic wait_idle;
        for (int t = 0; t < 3000; t++) begin
            @(negedge clk); #2;
            if (!busy && !inflight && !conv_start) break;
        end
    endtask

    task automatic wait_log(int target);
        for (int t = 0; t < 5000; t++) begin
            @(negedge clk);
            if (log_n >= target) break;
        end
    endtask

    task automatic read_ch(int ch, output logic [11:0] d, output logic v, output logic o);
        @(negedge clk);
        rd_chan = CH_W'(ch);
        rd_en   = 1'b1;
        #1 d = rd_data; v = rd_valid; o = rd_ovr;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic pop_one(output logic [11:0] d);
        @(negedge clk);
        #1 d = fifo_data;
        fifo_pop = 1'b1;
        @(negedge clk);
        fifo_pop = 1'b0;
    endtask

    task automatic run_single(int ch);
        cfg_mode = 2'd0;
        cfg_chan = CH_W'(ch);
        pulse_go;
        wait_idle;
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        repeat (150000) @(posedge clk);
        checks++; errs++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        logic [11:0] d;
        logic v, o;
        int base, cnt, k, ok;
        logic [NUM_CH-1:0] m;

        void'($urandom(32'd4711));
        rst_n = 1'b0; cfg_mode = '0; cfg_chan = '0; cfg_ch_en = '0;
        sw_go = 0; sw_stop = 0; ext_pin = 0; ext_en = 0; ext_fall = 0;
        tmr_ovf = '0; tmr_en = '0; pwm_trig = 0; pwm_en = 0;
        rd_en = 0; rd_chan = '0; fifo_pop = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;

        // R1 reset state
        chk("R1", "busy", int'(busy), 0);
        chk("R1", "conv_start", int'(conv_start), 0);
        chk("R1", "fifo_empty/full/ovr", int'({fifo_empty, fifo_full, fifo_ovr}), 4);
        ok = 1;
        for (int c = 0; c < NUM_CH; c++) begin
            read_ch(c, d, v, o);
            if (v || o) ok = 0;
        end
        chk("R1", "all flags clear", ok, 1);

        // R2 single conversions on random channels
        for (int it = 0; it < 6; it++) begin
            int ch;
            ch = int'($urandom % NUM_CH);
            base = log_n;
            run_single(ch);
            chk("R2", "one conversion", log_n - base, 1);
            chk("R2", "channel", log_ch[base], ch);
            chk("R2", "busy self-clear", int'(busy), 0);
            read_ch(ch, d, v, o);
            chk("R2", "data", int'(d), int'(log_d[base]));
            chk("R2", "valid", int'(v), 1);
        end

        // R3 single-pass scan with random masks
        for (int it = 0; it < 6; it++) begin
            m = NUM_CH'($urandom) | NUM_CH'(it == 0 ? 17'h10001 : 0);
            if (m == '0) m = 17'h00100;
            cnt = popc(m);
            cfg_mode = 2'd2; cfg_ch_en = m;
            base = log_n;
            pulse_go;
            wait_idle;
            chk("R3", "count", log_n - base, cnt);
            ok = 1;
            for (int j = 0; j < cnt; j++) if (log_ch[base + j] != nth_en(m, j)) ok = 0;
            chk("R3", "ascending order", ok, 1);
            chk("R3", "busy self-clear", int'(busy), 0);
            ok = 1;
            for (int j = 0; j < cnt; j++) begin
                read_ch(nth_en(m, j), d, v, o);
                if (d != log_d[base + j] || !v) ok = 0;
            end
            chk("R3", "stored results", ok, 1);
        end
        cfg_ch_en = '0;
        base = log_n;
        pulse_go;
        repeat (10) @(negedge clk);
        chk("R3", "empty mask ignored", log_n - base, 0);

        // R4 looping scan then stop
        m = 17'h12245;
        cnt = popc(m);
        cfg_mode = 2'd3; cfg_ch_en = m;
        base = log_n;
        pulse_go;
        wait_log(base + 2 * cnt + 1);
        pulse_stop;
        wait_idle;
        k = log_n - base;
        chk("R4", "ran over two passes", int'(k >= 2 * cnt + 1), 1);
        ok = 1;
        for (int j = 0; j < k; j++) if (log_ch[base + j] != nth_en(m, j % cnt)) ok = 0;
        chk("R4", "repeating ascending order", ok, 1);
        base = log_n;
        repeat (30) @(negedge clk);
        chk("R4", "no start after stop", log_n - base, 0);

        // R5 burst into queue
        read_ch(3, d, v, o);
        cfg_mode = 2'd1; cfg_chan = 5'd3;
        base = log_n;
        pulse_go;
        wait_log(base + 5);
        pulse_stop;
        wait_idle;
        k = log_n - base;
        chk("R5", "burst repeated", int'(k >= 5 && k <= 8), 1);
        ok = 1;
        for (int j = 0; j < k; j++) begin
            pop_one(d);
            if (d != log_d[base + j] || log_ch[base + j] != 3) ok = 0;
        end
        chk("R5", "queue order", ok, 1);
        chk("R5", "queue drained", int'(fifo_empty), 1);
        read_ch(3, d, v, o);
        chk("R5", "bank untouched", int'(v), 0);

        // R6 queue overflow
        base = log_n;
        pulse_go;
        wait_log(base + 11);
        pulse_stop;
        wait_idle;
        chk("R6", "full", int'(fifo_full), 1);
        chk("R6", "drop flag", int'(fifo_ovr), 1);
        pop_one(d);
        chk("R6", "oldest kept", int'(d), int'(log_d[base]));
        #1 chk("R6", "pop clears drop", int'(fifo_ovr), 0);
        ok = 1;
        for (int j = 1; j < 8; j++) begin
            pop_one(d);
            if (d != log_d[base + j]) ok = 0;
        end
        chk("R6", "first eight kept", ok, 1);
        chk("R6", "empty after eight", int'(fifo_empty), 1);

        // R7 trigger sources
        cfg_mode = 2'd0; cfg_chan = 5'd11;
        ext_en = 1'b1; ext_fall = 1'b0;
        base = log_n;
        @(negedge clk); ext_pin = 1'b1; wait_idle;
        chk("R7", "pin rising", log_n - base, 1);
        base = log_n;
        @(negedge clk); ext_pin = 1'b0; repeat (8) @(negedge clk);
        chk("R7", "pin falling ignored", log_n - base, 0);
        ext_fall = 1'b1;
        @(negedge clk); ext_pin = 1'b1; repeat (8) @(negedge clk);
        base = log_n;
        @(negedge clk); ext_pin = 1'b0; wait_idle;
        chk("R7", "pin falling", log_n - base, 1);
        ext_en = 1'b0;
        base = log_n;
        @(negedge clk); ext_pin = 1'b1; repeat (8) @(negedge clk);
        @(negedge clk); ext_pin = 1'b0; repeat (8) @(negedge clk);
        chk("R7", "pin disabled", log_n - base, 0);
        tmr_en = 4'b0100;
        base = log_n;
        @(negedge clk); tmr_ovf = 4'b0100; @(negedge clk); tmr_ovf = '0; wait_idle;
        chk("R7", "timer enabled", log_n - base, 1);
        base = log_n;
        @(negedge clk); tmr_ovf = 4'b1011; @(negedge clk); tmr_ovf = '0; repeat (8) @(negedge clk);
        chk("R7", "timers disabled", log_n - base, 0);
        pwm_en = 1'b1;
        base = log_n;
        @(negedge clk); pwm_trig = 1; @(negedge clk); pwm_trig = 0; wait_idle;
        chk("R7", "pwm enabled", log_n - base, 1);
        lat_fix = 6;
        base = log_n;
        pulse_go;
        @(negedge clk); @(negedge clk); pwm_trig = 1; @(negedge clk); pwm_trig = 0;
        wait_idle;
        chk("R7", "trigger while busy ignored", log_n - base, 1);
        pwm_en = 1'b0;
        base = log_n;
        @(negedge clk); pwm_trig = 1; @(negedge clk); pwm_trig = 0; repeat (8) @(negedge clk);
        chk("R7", "pwm disabled", log_n - base, 0);
        lat_fix = 0;

        // R8 / R9 overrun and read clear
        read_ch(7, d, v, o);
        base = log_n;
        run_single(7);
        read_ch(7, d, v, o);
        chk("R8", "no overrun after one", int'(o), 0);
        run_single(7);
        run_single(7);
        read_ch(7, d, v, o);
        chk("R8", "overrun set", int'(o), 1);
        chk("R9", "read data", int'(d), int'(log_d[log_n - 1]));
        chk("R9", "valid before clear", int'(v), 1);
        read_ch(7, d, v, o);
        chk("R9", "flags cleared", int'({v, o}), 0);

        // R10 read and write to one channel in the same cycle
        read_ch(9, d, v, o);
        run_single(9);
        base = log_n;
        lat_fix = 3;
        coll_arm = 1;
        run_single(9);
        lat_fix = 0;
        chk("R10", "old data on collision", int'(coll_old), int'(log_d[base - 1]));
        read_ch(9, d, v, o);
        chk("R10", "new data", int'(d), int'(log_d[base]));
        chk("R10", "valid kept, overrun clear", int'({v, o}), 2);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule